// File: doc/BRIEF.md
# Clock Ratio Change Sequencer

This block sequences changes of the clock ratios in a chip that has a single main clock domain. Software programs a frequency setting with two fields. One is a multiplication-ratio code that is passed to the PLL. The other is a peripheral division code that sets how often the peripheral clock enable fires. When software writes a setting that differs from the active one, the block enters a pause. During the pause it deasserts the internal and peripheral clock enables, and an 8-bit up-counting lock timer runs from a value software loaded beforehand. When the timer wraps past its top value, the block adopts the new setting, stops the timer and re-enables the clocks. The external clock-out enable is never interrupted.

Software reaches the block through a plain register bus. A write is one cycle with `reg_we` high. A read is combinational on `reg_addr`. The bus carries no data stream, so it has no valid/ready pair and no back-pressure: every write is taken in the cycle it is presented, or it is dropped under the rules below. The register map is: address 0 is the frequency setting, with the multiplication code in bits 5:3 and the division code in bits 2:0. Address 1 is control and status, with the hold bit in bit 0 and the busy flag (read-only) in bit 7. Address 2 is the timer count: a write preloads it and a read returns the live value. Address 3 is timer control, with the prescaler select in bits 2:0 and the stand-alone run bit in bit 7.

Top module: `clk_ratio_seq`

## Requirements
- R1: After reset the frequency register reads 0x03, meaning multiplication code 000 (ratio 1) and division code 011 (divide by 4). Control reads 0x00, `busy_o` is 0, `mul_ratio_o` is 000, and `core_clk_en` and `ext_clk_en` are both 1.
- R2: Outside a pause, `per_clk_en` is a one-cycle strobe every 1, 2 or 4 cycles for active division code 000, 001 or 011 respectively. After a pause ends, the first strobe falls in the first cycle.
- R3: A frequency write with a prohibited division code (010 or 1xx) is ignored. No pause starts and the register keeps its value.
- R4: While the control hold bit (bit 0) is 1, frequency writes are ignored.
- R5: An accepted frequency write whose value differs from the active setting raises busy (control bit 7 and `busy_o`) from the next cycle. While busy, `core_clk_en` and `per_clk_en` are 0. Writing the value that is already active starts no pause.
- R6: `ext_clk_en` stays 1 at all times, including during a pause.
- R7: The lock timer counts up by one every 2^k cycles, with k = 0, 2, 4, 5, 6, 8, 10, 12 for prescaler codes 000 to 111. With preload P, a pause lasts exactly (256-P)·2^k cycles.
- R8: When the timer wraps from 0xFF to 0x00, the written setting becomes active (it reads back and drives `mul_ratio_o`), busy clears, `core_clk_en` returns to 1, the run bit reads 0 and the count reads 0x00.
- R9: During a pause, writes to any register are ignored.
- R10: If the run bit is set while the block is idle, the timer counts in the same way without starting a pause. On wrap the run bit clears itself and the count stops at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| core_clk_en | output | 1 | Internal clock enable |
| per_clk_en | output | 1 | Peripheral clock enable strobe |
| ext_clk_en | output | 1 | External clock-out enable |
| mul_ratio_o | output | 3 | Active multiplication-ratio code |
| busy_o | output | 1 | Pause in progress |

## Verification
A fault in the active setting appears at `per_clk_en` within four cycles as a wrong strobe spacing, and at `mul_ratio_o` and in the read-back at once. A fault in the busy flag or the timer changes the length of a pause. That length is measured to the exact cycle for several preloads and prescaler codes, so a slip of one timer step or one prescaler cycle shows up when the pause ends. A write that should have been dropped is revealed by reading the register back, or by a pause that should not have started.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 8;
  localparam int FLD_W  = 3;
  localparam int CNT_W  = 8;
  localparam int SHIFT_W = 4;
  localparam int PRE_W  = 12;
  localparam int STB_W  = 2;
  localparam int TOP_BIT = REG_DW - 1;

  localparam logic [REG_AW-1:0] A_FRQ = 2'd0;
  localparam logic [REG_AW-1:0] A_CTL = 2'd1;
  localparam logic [REG_AW-1:0] A_CNT = 2'd2;
  localparam logic [REG_AW-1:0] A_TCS = 2'd3;

  typedef struct packed {
    logic [FLD_W-1:0] mult;
    logic [FLD_W-1:0] pdiv;
  } frq_t;

  localparam frq_t FRQ_RESET = '{mult: 3'b000, pdiv: 3'b011};

  function automatic logic pdiv_legal(input logic [FLD_W-1:0] code);
    return (code == 3'b000) || (code == 3'b001) || (code == 3'b011);
  endfunction

  function automatic logic [STB_W-1:0] pdiv_mask(input logic [FLD_W-1:0] code);
    case (code)
      3'b001:  return 2'b01;
      3'b011:  return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [SHIFT_W-1:0] psel_shift(input logic [FLD_W-1:0] code);
    case (code)
      3'd0: return 4'd0;
      3'd1: return 4'd2;
      3'd2: return 4'd4;
      3'd3: return 4'd5;
      3'd4: return 4'd6;
      3'd5: return 4'd8;
      3'd6: return 4'd10;
      default: return 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/crs_regs.sv
module crs_regs
  import crs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              busy,
  input  logic              ovf,
  input  logic [CNT_W-1:0]  count,
  output logic [REG_DW-1:0] rdata,
  output frq_t              frq_act,
  output logic              start,
  output logic [FLD_W-1:0]  psel,
  output logic              sw_run,
  output logic              cnt_load
);
  frq_t frq_pend;
  frq_t frq_new;
  logic hold_q;
  logic wr_ok;
  logic frq_wr;

  assign wr_ok   = we && !busy;
  assign frq_new = '{mult: wdata[2*FLD_W-1:FLD_W], pdiv: wdata[FLD_W-1:0]};
  assign frq_wr  = wr_ok && (addr == A_FRQ) && !hold_q && pdiv_legal(frq_new.pdiv);
  assign start   = frq_wr && (frq_new != frq_act);
  assign cnt_load = wr_ok && (addr == A_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frq_act  <= FRQ_RESET;
      frq_pend <= FRQ_RESET;
      hold_q   <= 1'b0;
      psel     <= '0;
      sw_run   <= 1'b0;
    end else begin
      if (start) frq_pend <= frq_new;
      if (busy && ovf) frq_act <= frq_pend;
      if (wr_ok && addr == A_CTL) hold_q <= wdata[0];
      if (wr_ok && addr == A_TCS) begin
        psel   <= wdata[FLD_W-1:0];
        sw_run <= wdata[TOP_BIT];
      end else if (ovf) begin
        sw_run <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_FRQ: rdata[2*FLD_W-1:0] = frq_act;
      A_CTL: begin
        rdata[0]       = hold_q;
        rdata[TOP_BIT] = busy;
      end
      A_CNT: rdata[CNT_W-1:0] = count;
      default: begin
        rdata[FLD_W-1:0] = psel;
        rdata[TOP_BIT]   = sw_run;
      end
    endcase
  end
endmodule

// File: rtl/crs_lock_timer.sv
module crs_lock_timer
  import crs_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = PRE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               load,
  input  logic [CW-1:0]      load_val,
  input  logic [SHIFT_W-1:0] shift,
  output logic [CW-1:0]      count,
  output logic               ovf
);
  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_lim;
  logic          tick;

  assign pre_lim = ({{(PW-1){1'b0}}, 1'b1} << shift) - 1'b1;
  assign tick    = run && (pre_q == pre_lim);
  assign ovf     = tick && (count == {CW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      count <= '0;
    end else begin
      if (!run || tick) pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
      if (load)      count <= load_val;
      else if (tick) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/crs_per_strobe.sv
module crs_per_strobe
  import crs_pkg::*;
#(
  parameter int SW = STB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pause,
  input  logic [FLD_W-1:0] pdiv,
  output logic             strobe
);
  logic [SW-1:0] phase_q;

  assign strobe = !pause && ((phase_q & pdiv_mask(pdiv)) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_q <= '0;
    else if (pause) phase_q <= '0;
    else            phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/clk_ratio_seq.sv
module clk_ratio_seq
  import crs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              core_clk_en,
  output logic              per_clk_en,
  output logic              ext_clk_en,
  output logic [FLD_W-1:0]  mul_ratio_o,
  output logic              busy_o
);
  frq_t             frq_act;
  logic             start;
  logic             ovf;
  logic             busy_q;
  logic [FLD_W-1:0] psel;
  logic             sw_run;
  logic             cnt_load;
  logic [CNT_W-1:0] count;

  crs_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy_q), .ovf(ovf), .count(count), .rdata(reg_rdata),
    .frq_act(frq_act), .start(start), .psel(psel), .sw_run(sw_run),
    .cnt_load(cnt_load)
  );

  crs_lock_timer u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy_q || sw_run), .load(cnt_load),
    .load_val(reg_wdata[CNT_W-1:0]), .shift(psel_shift(psel)),
    .count(count), .ovf(ovf)
  );

  crs_per_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .pause(busy_q), .pdiv(frq_act.pdiv),
    .strobe(per_clk_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_q <= 1'b0;
    else if (start) busy_q <= 1'b1;
    else if (ovf)   busy_q <= 1'b0;
  end

  assign core_clk_en = !busy_q;
  assign ext_clk_en  = rst_n;
  assign mul_ratio_o = frq_act.mult;
  assign busy_o      = busy_q;
endmodule

// File: rtl/crs_seq_checker.sv
module crs_seq_checker
  import crs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              busy,
  input logic              core_en,
  input logic              per_en,
  input logic              ext_en,
  input logic [FLD_W-1:0]  mult,
  input logic [FLD_W-1:0]  pdiv
);
  a_r6_ext_running: assert property (@(posedge clk) disable iff (!rst_n) ext_en);

  a_r5_gated_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!core_en && !per_en));

  a_r5_pause_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && reg_addr == A_FRQ));

  a_r8_ratio_changes_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (mult != $past(mult)) |-> ($past(busy) && !busy));

  a_r2_div1_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pdiv == 3'b000) |-> per_en);

  a_r2_div4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pdiv == 3'b011 && per_en) |=> !per_en);

  a_r3_active_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (pdiv == 3'b000) || (pdiv == 3'b001) || (pdiv == 3'b011));
endmodule

bind clk_ratio_seq crs_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .busy(busy_o), .core_en(core_clk_en), .per_en(per_clk_en),
  .ext_en(ext_clk_en), .mult(mul_ratio_o), .pdiv(frq_act.pdiv)
);

// File: tb/clk_ratio_seq_tb_top.sv
`timescale 1ns/1ps
module clk_ratio_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       core_clk_en, per_clk_en, ext_clk_en, busy_o;
  logic [2:0] mul_ratio_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] cur_frq = 8'h03;

  always #5 clk = ~clk;

  clk_ratio_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_clk_en(core_clk_en),
    .per_clk_en(per_clk_en), .ext_clk_en(ext_clk_en),
    .mul_ratio_o(mul_ratio_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic int shift_of(input int psel);
    int tbl[8] = '{0, 2, 4, 5, 6, 8, 10, 12};
    return tbl[psel];
  endfunction

  function automatic int div_of(input logic [2:0] code);
    return (code == 3'b000) ? 1 : (code == 3'b001) ? 2 : 4;
  endfunction

  // R2: strobe spacing; assumes the current sample is a strobe when aligned=1
  task automatic pattern(input int d, input bit aligned, input string tag);
    int waitc = 0;
    if (!aligned) begin
      while (!per_clk_en && waitc < 8) begin step(); waitc++; end
    end
    chk(per_clk_en === 1'b1, tag, per_clk_en, 1);
    for (int i = 1; i < 12; i++) begin
      step();
      chk(per_clk_en === ((i % d) == 0), tag, per_clk_en, (i % d) == 0);
    end
  endtask

  task automatic do_change(input logic [7:0] p, input int psel, input logic [7:0] tgt);
    int n = 0;
    int exp_n;
    bit gate_bad = 0;
    bit ext_bad = 0;
    logic [7:0] r;
    wr(2'd2, p);
    wr(2'd3, 8'(psel));
    wr(2'd0, tgt);
    rd(2'd1, r);
    chk(busy_o === 1'b1 && r[7], "R5 busy after write", r, 8'h80);
    while (busy_o && n < 20000) begin
      if (core_clk_en || per_clk_en) gate_bad = 1;
      if (!ext_clk_en) ext_bad = 1;
      step();
      n++;
    end
    exp_n = (256 - int'(p)) << shift_of(psel);
    chk(n == exp_n, "R7 pause length", n, exp_n);
    chk(!gate_bad, "R5 enables low in pause", gate_bad, 0);
    chk(!ext_bad, "R6 ext clock kept", ext_bad, 0);
    chk(core_clk_en === 1'b1, "R8 core clock back", core_clk_en, 1);
    rd(2'd0, r);
    chk(r == tgt, "R8 new setting read", r, tgt);
    chk(mul_ratio_o == tgt[5:3], "R8 mul ratio out", mul_ratio_o, tgt[5:3]);
    rd(2'd2, r);
    chk(r == 8'h00, "R8 count wrapped", r, 0);
    rd(2'd3, r);
    chk(r == 8'(psel), "R8 run bit clear", r, psel);
    cur_frq = tgt;
    pattern(div_of(tgt[2:0]), 1'b1, "R2 strobe after pause");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [2:0] codes[3] = '{3'b000, 3'b001, 3'b011};
    logic [7:0] pres[3] = '{8'hFF, 8'hFC, 8'hF0};
    int idx = 1;
    int n;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    rd(2'd0, r); chk(r == 8'h03, "R1 freq reset", r, 8'h03);
    rd(2'd1, r); chk(r == 8'h00, "R1 ctl reset", r, 0);
    chk(busy_o === 1'b0 && core_clk_en === 1'b1 && ext_clk_en === 1'b1,
        "R1 enables", {busy_o, core_clk_en, ext_clk_en}, 3'b011);
    chk(mul_ratio_o == 3'b000, "R1 ratio 1", mul_ratio_o, 0);
    pattern(4, 1'b0, "R2 divide by 4 at reset");

    // R3 prohibited codes
    wr(2'd0, 8'h0A);
    chk(busy_o === 1'b0, "R3 no pause on 010", busy_o, 0);
    wr(2'd0, 8'h3C);
    chk(busy_o === 1'b0, "R3 no pause on 100", busy_o, 0);
    rd(2'd0, r); chk(r == 8'h03, "R3 setting kept", r, 8'h03);

    // R4 hold bit
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h08);
    chk(busy_o === 1'b0, "R4 no pause while held", busy_o, 0);
    rd(2'd0, r); chk(r == 8'h03, "R4 setting kept", r, 8'h03);
    wr(2'd1, 8'h00);

    // R5 same value starts nothing
    wr(2'd0, 8'h03);
    chk(busy_o === 1'b0, "R5 same value no pause", busy_o, 0);

    // R7/R8 sweep over prescaler codes and preloads
    for (int ps = 0; ps < 4; ps++) begin
      for (int k = 0; k < 3; k++) begin
        do_change(pres[k], ps, {2'b00, 3'(idx % 8), codes[idx % 3]});
        idx++;
      end
    end
    do_change(8'hFF, 7, {2'b00, 3'd5, 3'b001});

    // R9 writes during pause ignored
    wr(2'd2, 8'hF0);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h1B);
    n = 0;
    wr(2'd2, 8'h00); n++;
    wr(2'd0, 8'h20); n++;
    wr(2'd1, 8'h01); n++;
    wr(2'd3, 8'h87); n++;
    while (busy_o && n < 1000) begin step(); n++; end
    chk(n == 16, "R9 pause length unchanged", n, 16);
    rd(2'd0, r); chk(r == 8'h1B, "R9 freq write dropped", r, 8'h1B);
    rd(2'd1, r); chk(r == 8'h00, "R9 ctl write dropped", r, 0);
    rd(2'd3, r); chk(r == 8'h00, "R9 tcs write dropped", r, 0);
    pattern(4, 1'b1, "R2 divide by 4 after pause");

    // R10 stand-alone timer run
    wr(2'd2, 8'hF0);
    wr(2'd3, 8'h80);
    repeat (5) step();
    rd(2'd2, r); chk(r == 8'hF5, "R10 counting", r, 8'hF5);
    chk(busy_o === 1'b0 && core_clk_en === 1'b1, "R10 no pause", busy_o, 0);
    repeat (11) step();
    rd(2'd3, r); chk(r == 8'h00, "R10 run self-clears", r, 0);
    rd(2'd2, r); chk(r == 8'h00, "R10 count wrapped", r, 0);
    repeat (4) step();
    rd(2'd2, r); chk(r == 8'h00, "R10 count stopped", r, 0);
    chk(ext_clk_en === 1'b1, "R6 ext clock at end", ext_clk_en, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule